// File: doc/BRIEF.md
# Serial Port FIFO Interrupt and DMA Request Controller

This block turns the status events of a FIFO-buffered serial port into interrupt and DMA request lines. Six event inputs hold the set condition of six sticky status flags. These are transmit FIFO empty, receive FIFO full, receive data ready, receive error, break and overrun. Three enable bits from a control register decide which flags become interrupt requests. Four interrupt lines come out: transmit (TXI), receive (RXI), receive error (ERI) and break (BRI). A priority code for an interrupt controller comes out beside them.

Two DMA request lines follow the flags alone and ignore the interrupt enables. A DMA engine can therefore move FIFO data while interrupts stay masked. An acknowledge from the DMA engine clears the flag behind its request. Software clears a flag in two steps: it reads the flag as 1, then writes 0 to that bit. A separate error enable lets the error and break interrupts through while the receive enable is off, so DMA-driven reception still reports line faults.

Top module: `uart_irq_dma_ctrl`

## Requirements
- R1: A flag is set in the cycle after its set input is sampled high and is visible on `status`. A set flag stays set until a clear described in R2 or R8. Status bit positions: 0 transmit empty, 1 receive full, 2 receive ready, 3 receive error, 4 break, 5 overrun.
- R2: A write (`wr_stb`) clears exactly those flags that were read as 1 by an earlier `rd_stb` and whose `wr_data` bit is 0. Writing 1 has no effect. Writing 0 to a flag that was not read as 1 since the last write has no effect.
- R3: If a flag's set input is high in the same cycle as a clear of that flag, the flag stays set.
- R4: `irq_txi` is high exactly when the transmit enable (`en_tx`) is 1 and the transmit empty flag is set.
- R5: `irq_rxi` is high exactly when the receive enable (`en_rx`) is 1 and the receive full flag or the receive ready flag is set. `en_err` alone never raises it.
- R6: `irq_eri` follows the receive error flag, and `irq_bri` follows the break flag OR the overrun flag. Each is passed when `en_rx` or `en_err` is 1.
- R7: `dma_tx_req` follows the transmit empty flag, and `dma_rx_req` follows receive full OR receive ready, whatever the enables are.
- R8: `dma_tx_ack` clears the transmit empty flag, and `dma_rx_ack` clears the receive full and receive ready flags. A flag whose set input is high in the same cycle stays set.
- R9: `irq_code` is 1 for ERI, 2 for RXI, 3 for BRI and 4 for TXI, taking the highest pending one in that order. It is 0 when no interrupt line is high.
- R10: Every request output and `irq_code` is registered. Each one changes one clock after the flag or enable it depends on. A synchronous reset clears all flags and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_tx_empty | input | 1 | Set condition, transmit FIFO empty |
| ev_rx_full | input | 1 | Set condition, receive FIFO at threshold |
| ev_rx_ready | input | 1 | Set condition, receive data ready |
| ev_rx_err | input | 1 | Set condition, receive error |
| ev_break | input | 1 | Set condition, break detected |
| ev_overrun | input | 1 | Set condition, overrun |
| en_tx | input | 1 | Transmit interrupt enable |
| en_rx | input | 1 | Receive interrupt enable |
| en_err | input | 1 | Receive error interrupt enable |
| rd_stb | input | 1 | Status read strobe |
| wr_stb | input | 1 | Status write strobe |
| wr_data | input | 6 | Status write data |
| dma_tx_ack | input | 1 | Transmit DMA acknowledge |
| dma_rx_ack | input | 1 | Receive DMA acknowledge |
| status | output | 6 | Flag register |
| irq_txi | output | 1 | Transmit interrupt request |
| irq_rxi | output | 1 | Receive interrupt request |
| irq_eri | output | 1 | Receive error interrupt request |
| irq_bri | output | 1 | Break/overrun interrupt request |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| irq_code | output | 3 | Highest priority pending source |

## Verification
A flag bit stuck at the wrong value shows on `status` one clock after the event or write. It shows on the request lines and `irq_code` one clock after that. A wrong enable gate or priority order leaves some combination of flag pattern and enable setting with the wrong request vector. For that reason the bench sweeps every flag pattern against every enable setting. Faults in the read-then-write sequence, in set-over-clear priority and in acknowledge handling appear on `status` in the cycle after the write or acknowledge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NFLAG = 6;
   localparam int F_TXE = 0;
   localparam int F_RXF = 1;
   localparam int F_RDY = 2;
   localparam int F_ERR = 3;
   localparam int F_BRK = 4;
   localparam int F_OVR = 5;

   localparam logic [2:0] SRC_NONE = 3'd0;
   localparam logic [2:0] SRC_ERI  = 3'd1;
   localparam logic [2:0] SRC_RXI  = 3'd2;
   localparam logic [2:0] SRC_BRI  = 3'd3;
   localparam logic [2:0] SRC_TXI  = 3'd4;

   typedef struct packed {
      logic eri;
      logic rxi;
      logic bri;
      logic txi;
   } irq_vec_t;
endpackage

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set_in,
   input  logic         rd_stb,
   input  logic         wr_stb,
   input  logic [N-1:0] wr_data,
   input  logic [N-1:0] ack_clr,
   output logic [N-1:0] q
);
   initial begin
      if (N < 1) $error("uart_irq_flags: N must be positive");
   end

   logic [N-1:0] armed;

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic sw_clr;
      logic q_nxt;
      assign sw_clr = wr_stb & armed[i] & ~wr_data[i];
      assign q_nxt  = set_in[i] | (q[i] & ~(sw_clr | ack_clr[i]));

      always_ff @(posedge clk) begin
         if (rst) begin
            q[i]     <= 1'b0;
            armed[i] <= 1'b0;
         end else begin
            q[i] <= q_nxt;
            if (rd_stb)      armed[i] <= q[i];
            else if (wr_stb) armed[i] <= 1'b0;
            else             armed[i] <= armed[i] & q_nxt;
         end
      end

      assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
         set_in[i] |=> q[i]);
      assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
         (q[i] && !wr_stb && !ack_clr[i]) |=> q[i]);
      assert_no_blind_clear_R2: assert property (@(posedge clk) disable iff (rst)
         (q[i] && !armed[i] && !ack_clr[i]) |=> q[i]);
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  irq_vec_t          req,
   output logic [CODE_W-1:0] code
);
   initial begin
      if (CODE_W < 3) $error("uart_irq_prio: CODE_W must be at least 3");
   end

   always_comb begin
      code = CODE_W'(SRC_NONE);
      if (req.eri)      code = CODE_W'(SRC_ERI);
      else if (req.rxi) code = CODE_W'(SRC_RXI);
      else if (req.bri) code = CODE_W'(SRC_BRI);
      else if (req.txi) code = CODE_W'(SRC_TXI);
   end
endmodule

// File: rtl/uart_irq_dma_ctrl.sv
module uart_irq_dma_ctrl
   import uart_irq_pkg::*;
#(
   parameter int CODE_W       = 3,
   parameter bit RX_DMA_READY = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ev_tx_empty,
   input  logic              ev_rx_full,
   input  logic              ev_rx_ready,
   input  logic              ev_rx_err,
   input  logic              ev_break,
   input  logic              ev_overrun,
   input  logic              en_tx,
   input  logic              en_rx,
   input  logic              en_err,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [5:0]        wr_data,
   input  logic              dma_tx_ack,
   input  logic              dma_rx_ack,
   output logic [5:0]        status,
   output logic              irq_txi,
   output logic              irq_rxi,
   output logic              irq_eri,
   output logic              irq_bri,
   output logic              dma_tx_req,
   output logic              dma_rx_req,
   output logic [CODE_W-1:0] irq_code
);
   initial begin
      if (CODE_W < 3) $error("uart_irq_dma_ctrl: CODE_W must be at least 3");
   end

   logic [NFLAG-1:0] set_vec, ack_vec, flg;
   irq_vec_t         req_c;
   logic [CODE_W-1:0] code_c;
   logic             rx_gate, rx_data_c, dma_rx_c;

   always_comb begin
      set_vec        = '0;
      set_vec[F_TXE] = ev_tx_empty;
      set_vec[F_RXF] = ev_rx_full;
      set_vec[F_RDY] = ev_rx_ready;
      set_vec[F_ERR] = ev_rx_err;
      set_vec[F_BRK] = ev_break;
      set_vec[F_OVR] = ev_overrun;
      ack_vec        = '0;
      ack_vec[F_TXE] = dma_tx_ack;
      ack_vec[F_RXF] = dma_rx_ack;
      ack_vec[F_RDY] = dma_rx_ack;
   end

   uart_irq_flags #(.N(NFLAG)) u_flags (
      .clk    (clk),
      .rst    (rst),
      .set_in (set_vec),
      .rd_stb (rd_stb),
      .wr_stb (wr_stb),
      .wr_data(wr_data),
      .ack_clr(ack_vec),
      .q      (flg)
   );

   assign status    = flg;
   assign rx_gate   = en_rx | en_err;
   assign rx_data_c = flg[F_RXF] | flg[F_RDY];

   generate
      if (RX_DMA_READY) begin : g_rxdma_both
         assign dma_rx_c = flg[F_RXF] | flg[F_RDY];
      end else begin : g_rxdma_full
         assign dma_rx_c = flg[F_RXF];
      end
   endgenerate

   always_comb begin
      req_c.txi = en_tx & flg[F_TXE];
      req_c.rxi = en_rx & rx_data_c;
      req_c.eri = rx_gate & flg[F_ERR];
      req_c.bri = rx_gate & (flg[F_BRK] | flg[F_OVR]);
   end

   uart_irq_prio #(.CODE_W(CODE_W)) u_prio (
      .req (req_c),
      .code(code_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_txi    <= 1'b0;
         irq_rxi    <= 1'b0;
         irq_eri    <= 1'b0;
         irq_bri    <= 1'b0;
         dma_tx_req <= 1'b0;
         dma_rx_req <= 1'b0;
         irq_code   <= '0;
      end else begin
         irq_txi    <= req_c.txi;
         irq_rxi    <= req_c.rxi;
         irq_eri    <= req_c.eri;
         irq_bri    <= req_c.bri;
         dma_tx_req <= flg[F_TXE];
         dma_rx_req <= dma_rx_c;
         irq_code   <= code_c;
      end
   end

   assert_reset_clears_R10: assert property (@(posedge clk)
      rst |=> !(irq_txi | irq_rxi | irq_eri | irq_bri | dma_tx_req | dma_rx_req));
   assert_dma_tx_follows_R7: assert property (@(posedge clk) disable iff (rst)
      flg[F_TXE] |=> dma_tx_req);
   assert_err_path_R6: assert property (@(posedge clk) disable iff (rst)
      (flg[F_ERR] && en_err && !en_rx) |=> irq_eri);
   assert_rxi_masked_R5: assert property (@(posedge clk) disable iff (rst)
      !en_rx |=> !irq_rxi);
   assert_code_none_R9: assert property (@(posedge clk) disable iff (rst)
      (irq_code == '0) |-> !(irq_txi | irq_rxi | irq_eri | irq_bri));
   assert_code_eri_top_R9: assert property (@(posedge clk) disable iff (rst)
      irq_eri |-> (irq_code == CODE_W'(SRC_ERI)));
endmodule

// File: tb/uart_irq_dma_ctrl_bench.sv
module uart_irq_dma_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [5:0] ev = '0;
   logic en_tx = 0, en_rx = 0, en_err = 0;
   logic rd_stb = 0, wr_stb = 0;
   logic [5:0] wr_data = '0;
   logic dma_tx_ack = 0, dma_rx_ack = 0;
   logic [5:0] status;
   logic irq_txi, irq_rxi, irq_eri, irq_bri, dma_tx_req, dma_rx_req;
   logic [2:0] irq_code;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_irq_dma_ctrl u_uart_irq_dma_ctrl (
      .clk(clk), .rst(rst),
      .ev_tx_empty(ev[0]), .ev_rx_full(ev[1]), .ev_rx_ready(ev[2]),
      .ev_rx_err(ev[3]), .ev_break(ev[4]), .ev_overrun(ev[5]),
      .en_tx(en_tx), .en_rx(en_rx), .en_err(en_err),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
      .dma_tx_ack(dma_tx_ack), .dma_rx_ack(dma_rx_ack),
      .status(status),
      .irq_txi(irq_txi), .irq_rxi(irq_rxi), .irq_eri(irq_eri), .irq_bri(irq_bri),
      .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .irq_code(irq_code)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [8:0] expect_vec(input logic [5:0] p, input logic [2:0] e);
      logic txi, rxi, eri, bri, dtx, drx;
      logic [2:0] code;
      txi = e[0] & p[0];
      rxi = e[1] & (p[1] | p[2]);
      eri = (e[1] | e[2]) & p[3];
      bri = (e[1] | e[2]) & (p[4] | p[5]);
      dtx = p[0];
      drx = p[1] | p[2];
      code = eri ? 3'd1 : rxi ? 3'd2 : bri ? 3'd3 : txi ? 3'd4 : 3'd0;
      return {code, eri, rxi, bri, txi, dtx, drx};
   endfunction

   function automatic logic [8:0] out_vec();
      return {irq_code, irq_eri, irq_rxi, irq_bri, irq_txi, dma_tx_req, dma_rx_req};
   endfunction

   task automatic clear_all();
      @(negedge clk); rd_stb = 1;
      @(negedge clk); rd_stb = 0; wr_stb = 1; wr_data = '0;
      @(negedge clk); wr_stb = 0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset outputs", 32'(out_vec()), 32'h0);
      chk("R10 reset status", 32'(status), 32'h0);
      rst = 0;

      // latency: flag one clock, request one clock later
      @(negedge clk); ev = 6'b000001;
      @(negedge clk); ev = '0;
      chk("R1 flag visible", 32'(status), 32'h01);
      chk("R10 dma not yet", 32'(dma_tx_req), 32'h0);
      @(negedge clk);
      chk("R10 dma after one clock", 32'(dma_tx_req), 32'h1);
      clear_all();

      // sweep every flag pattern against every enable setting
      for (int p = 0; p < 64; p++) begin
         @(negedge clk); ev = 6'(p); en_tx = 0; en_rx = 0; en_err = 0;
         @(negedge clk); ev = '0;
         chk("R1 pattern set", 32'(status), 32'(p));
         for (int e = 0; e < 8; e++) begin
            @(negedge clk);
            {en_err, en_rx, en_tx} = 3'(e);
            @(negedge clk);
            chk("R4 R5 R6 R7 R9 sweep", 32'(out_vec()), 32'(expect_vec(6'(p), 3'(e))));
         end
         clear_all();
         chk("R2 read then write zero", 32'(status), 32'h0);
      end

      // R2 corner cases
      @(negedge clk); ev = 6'h3F;
      @(negedge clk); ev = '0; wr_stb = 1; wr_data = '0;
      @(negedge clk); wr_stb = 0;
      chk("R2 write without read", 32'(status), 32'h3F);
      @(negedge clk); rd_stb = 1;
      @(negedge clk); rd_stb = 0; wr_stb = 1; wr_data = 6'b111110;
      @(negedge clk); wr_stb = 0;
      chk("R2 write ones keeps", 32'(status), 32'h3E);
      @(negedge clk); wr_stb = 1; wr_data = '0;
      @(negedge clk); wr_stb = 0;
      chk("R2 read consumed", 32'(status), 32'h3E);
      clear_all();
      chk("R2 all cleared", 32'(status), 32'h0);

      // R3 set beats clear
      @(negedge clk); ev = 6'b001000;
      @(negedge clk); ev = '0; rd_stb = 1;
      @(negedge clk); rd_stb = 0; wr_stb = 1; wr_data = '0; ev = 6'b001000;
      @(negedge clk); wr_stb = 0; ev = '0;
      chk("R3 set wins over clear", 32'(status), 32'h08);
      clear_all();

      // R8 DMA acknowledge
      en_tx = 0; en_rx = 0; en_err = 0;
      @(negedge clk); ev = 6'b001111;
      @(negedge clk); ev = '0; dma_tx_ack = 1;
      @(negedge clk); dma_tx_ack = 0;
      chk("R8 tx ack clears", 32'(status), 32'h0E);
      @(negedge clk);
      chk("R8 tx request drops", 32'(dma_tx_req), 32'h0);
      dma_rx_ack = 1;
      @(negedge clk); dma_rx_ack = 0;
      chk("R8 rx ack clears two", 32'(status), 32'h08);
      @(negedge clk);
      chk("R8 rx request drops", 32'(dma_rx_req), 32'h0);
      ev = 6'b000001;
      @(negedge clk); dma_tx_ack = 1;
      @(negedge clk); dma_tx_ack = 0; ev = '0;
      chk("R8 ack with set held", 32'(status), 32'h09);
      @(negedge clk);
      chk("R7 dma with enables off", 32'(dma_tx_req), 32'h1);

      // R10 reset mid-run
      rst = 1;
      @(negedge clk); rst = 0;
      chk("R10 reset clears flags", 32'(status), 32'h0);
      chk("R10 reset clears outputs", 32'(out_vec()), 32'h0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule